// File: doc/BRIEF.md
# Internal-Bus Abort Error Reporter

This block sits beside the inbound write path of a bridge that forwards writes from an external PCI-style bus onto an internal bus. When the internal master interface finds that an inbound write has not been claimed by any internal target (a master abort), it sends this block a one-cycle report. The block records the abort in sticky interrupt-status and bus-status registers. Depending on a pair of enables, it drives a one-cycle active-low system-error strobe. It also raises a level interrupt toward the local processor. Finally, it sends a one-cycle flush command, carrying the queue tag of the aborted entry, back to the inbound write queue.

Software clears status bits by writing a 1 to them. The abort bit in the interrupt status cannot be masked: while it is set, the interrupt is asserted. The two secondary interrupt bits that report the system-error strobe each follow their own mask or enable, which is sampled in the cycle of the abort.

The flush output is a plain strobe with no valid/ready handshake. The queue must accept it in the cycle it appears, because an abort cannot be held back. The abort report input has no back-pressure for the same reason.

Top module: `xbus_abort_reporter`

## Requirements
- R1: A report with `ab_vld`=1 and `ab_write`=1 sets interrupt-status bit 7 (`isr_q[7]`, abort) on the next clock edge.
- R2: `serr_n` is driven low for exactly the one cycle after a write abort, and only when both `en_cmd_serr` and `en_inb_serr` are 1 in the abort cycle. It stays high in every other case.
- R3: Each cycle in which `serr_n` is low, status bit 14 (`sr_q[14]`, system-error-asserted) is set in that same cycle.
- R4: When `serr_n` is driven low and `msk_serr_int` was 0 in the abort cycle, interrupt-status bit 4 (`isr_q[4]`, system-error-asserted) is set alongside it. When `msk_serr_int` was 1, bit 4 is left unchanged.
- R5: When `serr_n` is driven low and `en_serr_det_int` was 1 in the abort cycle, interrupt-status bit 5 (`isr_q[5]`, system-error-detected) is set alongside it. When `en_serr_det_int` was 0, bit 5 is left unchanged.
- R6: Each write abort produces `flush_vld`=1 for exactly the following cycle, with `flush_tag` equal to the `ab_tag` of the report. Back-to-back aborts give back-to-back flushes.
- R7: While `isr_q[7]` is 1, `irq` is 1, whatever the value of `msk_serr_int`.
- R8: `irq` is, in the same cycle, `isr_q[7] | (isr_q[4] & ~msk_serr_int) | isr_q[5]`. It uses the current value of `msk_serr_int`.
- R9: A write with `isr_clr_we`=1 (or `sr_clr_we`=1) clears, on the next edge, each bit where the data holds 1, and leaves the other bits unchanged. A bit being set in the same cycle stays 1.
- R10: A report with `ab_vld`=1 and `ab_write`=0 (an inbound read) changes no status bit and produces no `serr_n` or `flush_vld` pulse.
- R11: Synchronous active-high `rst` clears `isr_q` and `sr_q`, holds `serr_n` at 1, and holds `flush_vld` and `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ab_vld | input | 1 | One-cycle master-abort report from the internal master |
| ab_write | input | 1 | 1 when the aborted transaction was an inbound write |
| ab_tag | input | TAG_W | Inbound write queue tag of the aborted entry |
| en_cmd_serr | input | 1 | System-error enable from the command register |
| en_inb_serr | input | 1 | Inbound-error system-error enable from the mask register |
| msk_serr_int | input | 1 | Mask for the system-error-asserted interrupt bit |
| en_serr_det_int | input | 1 | Enable for the system-error-detected interrupt bit |
| isr_clr_we | input | 1 | Write-one-to-clear strobe for the interrupt status |
| isr_clr_data | input | ISR_W | Bits to clear in the interrupt status |
| sr_clr_we | input | 1 | Write-one-to-clear strobe for the bus status |
| sr_clr_data | input | SR_W | Bits to clear in the bus status |
| isr_q | output | ISR_W | Interrupt status register |
| sr_q | output | SR_W | Bus status register |
| serr_n | output | 1 | Active-low system-error strobe |
| irq | output | 1 | Level interrupt to the local processor |
| flush_vld | output | 1 | One-cycle flush command to the inbound write queue |
| flush_tag | output | TAG_W | Queue tag to flush |

## Verification
The stimulus includes a write abort under all sixteen combinations of the four control bits. This shows that the strobe needs both enables, and that each secondary interrupt bit follows only its own gate. Read aborts mixed in among write aborts show that only the write direction counts. Back-to-back aborts with distinct tags test that flush pulses and tags do not merge. Clears that arrive in the same cycle as a new event, and clears with a partial mask, separate set-over-clear priority from plain write-one-to-clear behaviour. Toggling the mask while bits are set shows that the abort bit alone keeps the interrupt up.

// File: rtl/xbus_abort_pkg.sv
package xbus_abort_pkg;
  localparam int unsigned ISR_ABORT_BIT = 7;
  localparam int unsigned ISR_SA_BIT    = 4;
  localparam int unsigned ISR_SD_BIT    = 5;
  localparam int unsigned SR_SA_BIT     = 14;

  typedef struct packed {
    logic fire;
    logic serr;
    logic sa_int;
    logic sd_int;
  } abort_ev_t;
endpackage

// File: rtl/xbus_abort_qualify.sv
module xbus_abort_qualify
  import xbus_abort_pkg::*;
(
  input  logic      ab_vld,
  input  logic      ab_write,
  input  logic      en_cmd_serr,
  input  logic      en_inb_serr,
  input  logic      msk_serr_int,
  input  logic      en_serr_det_int,
  output abort_ev_t ev
);
  always_comb begin
    ev.fire   = ab_vld & ab_write;
    ev.serr   = ev.fire & en_cmd_serr & en_inb_serr;
    ev.sa_int = ev.serr & ~msk_serr_int;
    ev.sd_int = ev.serr & en_serr_det_int;
  end
endmodule

// File: rtl/xbus_w1c_bank.sv
module xbus_w1c_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                    q[b] <= 1'b0;
      else if (set_i[b])          q[b] <= 1'b1;
      else if (clr_we && clr_i[b]) q[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/xbus_irq_merge.sv
module xbus_irq_merge #(
  parameter int unsigned W         = 8,
  parameter int unsigned ABORT_BIT = 7
) (
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] eff_mask;
  always_comb begin
    eff_mask            = mask;
    eff_mask[ABORT_BIT] = 1'b0;
    irq                 = |(status & ~eff_mask);
  end
endmodule

// File: rtl/xbus_abort_reporter.sv
module xbus_abort_reporter
  import xbus_abort_pkg::*;
#(
  parameter int unsigned TAG_W = 4,
  parameter int unsigned ISR_W = 8,
  parameter int unsigned SR_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ab_vld,
  input  logic             ab_write,
  input  logic [TAG_W-1:0] ab_tag,
  input  logic             en_cmd_serr,
  input  logic             en_inb_serr,
  input  logic             msk_serr_int,
  input  logic             en_serr_det_int,
  input  logic             isr_clr_we,
  input  logic [ISR_W-1:0] isr_clr_data,
  input  logic             sr_clr_we,
  input  logic [SR_W-1:0]  sr_clr_data,
  output logic [ISR_W-1:0] isr_q,
  output logic [SR_W-1:0]  sr_q,
  output logic             serr_n,
  output logic             irq,
  output logic             flush_vld,
  output logic [TAG_W-1:0] flush_tag
);
  abort_ev_t        ev;
  logic [ISR_W-1:0] isr_set;
  logic [SR_W-1:0]  sr_set;
  logic [ISR_W-1:0] irq_mask;

  xbus_abort_qualify u_qual (
    .ab_vld          (ab_vld),
    .ab_write        (ab_write),
    .en_cmd_serr     (en_cmd_serr),
    .en_inb_serr     (en_inb_serr),
    .msk_serr_int    (msk_serr_int),
    .en_serr_det_int (en_serr_det_int),
    .ev              (ev)
  );

  always_comb begin
    isr_set                = '0;
    isr_set[ISR_ABORT_BIT] = ev.fire;
    isr_set[ISR_SA_BIT]    = ev.sa_int;
    isr_set[ISR_SD_BIT]    = ev.sd_int;
    sr_set                 = '0;
    sr_set[SR_SA_BIT]      = ev.serr;
    irq_mask               = '0;
    irq_mask[ISR_SA_BIT]   = msk_serr_int;
  end

  xbus_w1c_bank #(.W(ISR_W)) u_isr (
    .clk    (clk),
    .rst    (rst),
    .set_i  (isr_set),
    .clr_we (isr_clr_we),
    .clr_i  (isr_clr_data),
    .q      (isr_q)
  );

  xbus_w1c_bank #(.W(SR_W)) u_sr (
    .clk    (clk),
    .rst    (rst),
    .set_i  (sr_set),
    .clr_we (sr_clr_we),
    .clr_i  (sr_clr_data),
    .q      (sr_q)
  );

  xbus_irq_merge #(.W(ISR_W), .ABORT_BIT(ISR_ABORT_BIT)) u_irq (
    .status (isr_q),
    .mask   (irq_mask),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      serr_n    <= 1'b1;
      flush_vld <= 1'b0;
      flush_tag <= '0;
    end else begin
      serr_n    <= ~ev.serr;
      flush_vld <= ev.fire;
      if (ev.fire) flush_tag <= ab_tag;
    end
  end
endmodule

// File: rtl/xbus_abort_reporter_chk.sv
module xbus_abort_reporter_chk
  import xbus_abort_pkg::*;
#(
  parameter int unsigned TAG_W = 4,
  parameter int unsigned ISR_W = 8,
  parameter int unsigned SR_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ab_vld,
  input logic             ab_write,
  input logic [TAG_W-1:0] ab_tag,
  input logic             en_cmd_serr,
  input logic             en_inb_serr,
  input logic             msk_serr_int,
  input logic             en_serr_det_int,
  input logic             isr_clr_we,
  input logic [ISR_W-1:0] isr_clr_data,
  input logic [ISR_W-1:0] isr_q,
  input logic [SR_W-1:0]  sr_q,
  input logic             serr_n,
  input logic             irq,
  input logic             flush_vld,
  input logic [TAG_W-1:0] flush_tag
);
  assert_abort_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (ab_vld && ab_write) |=> isr_q[ISR_ABORT_BIT]);

  assert_serr_gated_R2: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> $past(ab_vld && ab_write && en_cmd_serr && en_inb_serr));

  assert_serr_status_R3: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> sr_q[SR_SA_BIT]);

  assert_sa_int_R4: assert property (@(posedge clk) disable iff (rst)
    (!serr_n && !$past(msk_serr_int)) |-> isr_q[ISR_SA_BIT]);

  assert_sd_int_R5: assert property (@(posedge clk) disable iff (rst)
    (!serr_n && $past(en_serr_det_int)) |-> isr_q[ISR_SD_BIT]);

  assert_flush_tag_R6: assert property (@(posedge clk) disable iff (rst)
    (ab_vld && ab_write) |=> (flush_vld && flush_tag == $past(ab_tag)));

  assert_abort_irq_R7: assert property (@(posedge clk) disable iff (rst)
    isr_q[ISR_ABORT_BIT] |-> irq);

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (isr_clr_we && isr_clr_data[ISR_ABORT_BIT] && !(ab_vld && ab_write))
      |=> !isr_q[ISR_ABORT_BIT]);

  assert_read_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (ab_vld && !ab_write) |=> (serr_n && !flush_vld));

  assert_reset_R11: assert property (@(posedge clk)
    $past(rst) |-> (isr_q == '0 && serr_n && !flush_vld && !irq));
endmodule

bind xbus_abort_reporter xbus_abort_reporter_chk #(
  .TAG_W(TAG_W), .ISR_W(ISR_W), .SR_W(SR_W)
) u_chk (
  .clk(clk), .rst(rst), .ab_vld(ab_vld), .ab_write(ab_write), .ab_tag(ab_tag),
  .en_cmd_serr(en_cmd_serr), .en_inb_serr(en_inb_serr),
  .msk_serr_int(msk_serr_int), .en_serr_det_int(en_serr_det_int),
  .isr_clr_we(isr_clr_we), .isr_clr_data(isr_clr_data),
  .isr_q(isr_q), .sr_q(sr_q), .serr_n(serr_n), .irq(irq),
  .flush_vld(flush_vld), .flush_tag(flush_tag)
);

// File: tb/xbus_abort_reporter_test.sv
module xbus_abort_reporter_test;
  localparam int TAG_W = 4;
  localparam int ISR_W = 8;
  localparam int SR_W  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst = 1'b1;
  logic             ab_vld = 0, ab_write = 0;
  logic [TAG_W-1:0] ab_tag = '0;
  logic             en_cmd_serr = 0, en_inb_serr = 0, msk_serr_int = 0, en_serr_det_int = 0;
  logic             isr_clr_we = 0, sr_clr_we = 0;
  logic [ISR_W-1:0] isr_clr_data = '0;
  logic [SR_W-1:0]  sr_clr_data = '0;
  logic [ISR_W-1:0] isr_q;
  logic [SR_W-1:0]  sr_q;
  logic             serr_n, irq, flush_vld;
  logic [TAG_W-1:0] flush_tag;

  xbus_abort_reporter #(.TAG_W(TAG_W), .ISR_W(ISR_W), .SR_W(SR_W)) uut (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic done = 0;

  // reference state
  logic [ISR_W-1:0] m_isr = '0;
  logic [SR_W-1:0]  m_sr = '0;
  logic             m_serr_n = 1, m_flush = 0;
  logic [TAG_W-1:0] m_tag = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // advance one clock: update model at posedge, compare at negedge
  task automatic step();
    logic ev, se;
    @(posedge clk);
    if (rst) begin
      m_isr = '0; m_sr = '0; m_serr_n = 1; m_flush = 0; m_tag = '0;
    end else begin
      ev = ab_vld & ab_write;
      se = ev & en_cmd_serr & en_inb_serr;
      if (isr_clr_we) m_isr = m_isr & ~isr_clr_data;
      if (sr_clr_we)  m_sr  = m_sr & ~sr_clr_data;
      if (ev) m_isr[7] = 1;
      if (se && !msk_serr_int) m_isr[4] = 1;
      if (se && en_serr_det_int) m_isr[5] = 1;
      if (se) m_sr[14] = 1;
      m_serr_n = !se;
      m_flush  = ev;
      if (ev) m_tag = ab_tag;
    end
    @(negedge clk);
    chk("R1 abort bit", 32'(isr_q[7]), 32'(m_isr[7]));
    chk("R4 serr-asserted int bit", 32'(isr_q[4]), 32'(m_isr[4]));
    chk("R5 serr-detected int bit", 32'(isr_q[5]), 32'(m_isr[5]));
    chk("R9 whole isr", 32'(isr_q), 32'(m_isr));
    chk("R3 status serr bit", 32'(sr_q), 32'(m_sr));
    chk("R2 serr_n", 32'(serr_n), 32'(m_serr_n));
    chk("R6 flush_vld", 32'(flush_vld), 32'(m_flush));
    if (m_flush) chk("R6 flush_tag", 32'(flush_tag), 32'(m_tag));
    chk("R8 irq", 32'(irq),
        32'(m_isr[7] | (m_isr[4] & ~msk_serr_int) | m_isr[5]));
    if (m_isr[7]) chk("R7 irq with abort bit", 32'(irq), 32'd1);
  endtask

  task automatic idle();
    ab_vld = 0; ab_write = 0; isr_clr_we = 0; sr_clr_we = 0;
    isr_clr_data = '0; sr_clr_data = '0;
  endtask

  task automatic clear_all();
    isr_clr_we = 1; isr_clr_data = '1; sr_clr_we = 1; sr_clr_data = '1;
    step();
    idle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    ab_vld = 1; ab_write = 1;
    step(); step();
    chk("R11 reset isr", 32'(isr_q), 32'd0);
    chk("R11 reset serr_n/flush/irq", {29'd0, serr_n, flush_vld, irq}, 32'b100);
    rst = 0; idle();
    step();

    // all control combos with a write abort
    for (int c = 0; c < 16; c++) begin
      {en_cmd_serr, en_inb_serr, msk_serr_int, en_serr_det_int} = 4'(c);
      ab_vld = 1; ab_write = 1; ab_tag = 4'(c);
      step();
      idle();
      step();
      step();
      if (c[3] && c[2]) chk("R2 serr strobe fired then released", 32'(serr_n), 32'd1);
      clear_all();
    end

    // read aborts ignored (R10)
    en_cmd_serr = 1; en_inb_serr = 1; msk_serr_int = 0; en_serr_det_int = 1;
    ab_vld = 1; ab_write = 0; ab_tag = 4'h9;
    step();
    chk("R10 read leaves status", {16'(isr_q), sr_q}, 32'd0);
    chk("R10 read no pulses", {30'd0, serr_n, flush_vld}, 32'b10);
    idle(); step();

    // back-to-back aborts, distinct tags
    for (int k = 0; k < 4; k++) begin
      ab_vld = 1; ab_write = 1; ab_tag = 4'(k + 3);
      step();
      chk("R6 back-to-back flush", 32'(flush_tag), 32'(k + 3));
    end
    idle(); step();

    // mask toggling with bits set (R7 R8)
    msk_serr_int = 1; #1;
    chk("R7 irq held by abort bit", 32'(irq), 32'd1);
    isr_clr_we = 1; isr_clr_data = 8'h80; step(); idle();
    msk_serr_int = 1; #1;
    chk("R8 irq with sd bit only", 32'(irq), 32'd1);
    isr_clr_we = 1; isr_clr_data = 8'h20; step(); idle();
    #1 chk("R8 irq masked sa bit", 32'(irq), 32'd0);
    msk_serr_int = 0; #1;
    chk("R8 irq unmasked sa bit", 32'(irq), 32'd1);
    step();
    clear_all();

    // set wins over clear, partial clear
    en_serr_det_int = 1; msk_serr_int = 0;
    ab_vld = 1; ab_write = 1; ab_tag = 4'hA;
    isr_clr_we = 1; isr_clr_data = 8'hFF; sr_clr_we = 1; sr_clr_data = '1;
    step();
    chk("R9 set over clear", 32'(isr_q), 32'hB0);
    idle();
    isr_clr_we = 1; isr_clr_data = 8'h10;
    step();
    chk("R9 partial clear", 32'(isr_q), 32'hA0);
    idle();
    isr_clr_we = 1; isr_clr_data = 8'h00;
    step();
    chk("R9 zero data no clear", 32'(isr_q), 32'hA0);
    idle();
    sr_clr_we = 1; sr_clr_data = 16'h4000;
    step();
    chk("R9 status clear", 32'(sr_q), 32'd0);
    idle(); step();

    // reset mid-run
    rst = 1; step();
    chk("R11 reset clears", {16'(isr_q), sr_q}, 32'd0);
    rst = 0; step();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule